// File: doc/BRIEF.md
# Open-Drain Serial Bus Access Arbiter

This block decides which of several devices sharing an open-drain upstream serial line may use a common transfer channel. Once per frame a control octet passes on the line. One bit of that octet is a bus-free flag. Three further bits carry the address of a device that is contending for the channel. Every device drives only zeros and releases the line for ones, so the line carries the wired-AND of all drivers.

A device wants the channel when its software request bit is set or when it has a frame waiting to send. It waits for a control octet whose flag reads free. It then sends its programmed address, most significant bit first, and checks each bit it reads back. A device that sends a one and reads a zero has lost, so the lowest address wins. The winner holds the channel and pulls the flag low in every later control octet until its request is removed. It must then see two successive free frames before it may contend again. When nobody contends, the line idles high and the address reads back as 7, so a device programmed with address 7 holds the channel by default.

Top module: `wab_arbiter`

## Requirements
- R1: Either `sw_req` or `tx_pend` being high is a request. A request starts arbitration at the flag sample of the next control octet whose flag reads free, provided the back-off allows it.
- R2: Arbitration starts only when the flag bit (octet bit position 5) is sampled as 1. If it is sampled as 0, the block does not start arbitrating in that octet.
- R3: The address goes out most significant bit first, in bit positions 4, 3 and 2. `drv_en` is high only inside the control octet, only in the slot of an address bit that is 0, or in the flag slot while the channel is held. It is never high in positions 7, 6, 1 or 0.
- R4: If the block sends a 1 and samples a 0, it drives none of the remaining address bits of that octet and does not win. With several contenders, the lowest address wins.
- R5: After the last address bit (position 2) has been sampled with no mismatch, `grant` rises on the next cycle. From then on the flag slot of every control octet is driven low while the request stays high.
- R6: When both request inputs are low, a held channel is released and `grant` falls on the next cycle. The flag is not driven in any later octet.
- R7: After a win, the block may not arbitrate again until it has sampled the flag free in two successive octets. It may arbitrate in the second of those octets. An octet with the flag at 0 restarts the count.
- R8: A block programmed with address 7 raises `grant` one cycle after the position-2 sample of an octet in which the flag read 1 and the address field read 7. It lowers `grant` after the position-2 sample of an octet that shows anything else, unless it holds the channel through arbitration.
- R9: While reset is asserted and after it is released, `drv_en` and `grant` are 0 and no back-off is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| my_addr | input | ADDR_W | Programmed arbitration address (lower value has higher priority) |
| sw_req | input | 1 | Software request bit |
| tx_pend | input | 1 | A frame is waiting to be sent |
| octet_act | input | 1 | High while the control octet is on the line |
| bit_pos | input | POS_W | Position of the current bit in the control octet (7 first) |
| bit_smp | input | 1 | One-cycle strobe: sample the line for the current bit |
| line_in | input | 1 | Value read from the shared line |
| drv_en | output | 1 | Pull the shared line low |
| grant | output | 1 | Block holds the channel, by arbitration or by default |

## Verification
`drv_en` is combinational from registered state and the timing inputs. It is therefore due in the same cycle in which `bit_pos` names a slot. The bench compares it 3 ns after each falling edge, once the inputs driven at that edge have settled. Arbitration results, `grant` and the default grant are registered on the rising edge that carries `bit_smp`, and a request removal acts on the next rising edge. The bench's behavioural model applies its updates on the same edges, so both are compared on every clock. The scenario checks read the line values captured in each sample slot. They test `grant` only after the octet has ended, when every registered result has landed.

// File: rtl/wab_pkg.sv
package wab_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_RUN  = 2'd1,
    ARB_HOLD = 2'd2
  } arb_st_e;
endpackage

// File: rtl/wab_rst_sync.sv
module wab_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/wab_backoff.sv
module wab_backoff #(
  parameter int FREE_FRAMES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win,
  input  logic flag_smp,
  input  logic flag_free,
  output logic ok
);
  localparam int CNT_W = $clog2(FREE_FRAMES + 1);

  logic             blk_q, blk_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   cnt_inc;
  logic             reached;

  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign reached = (cnt_inc >= (CNT_W+1)'(FREE_FRAMES));

  // valid while flag_smp is high: this sample may complete the back-off
  assign ok = !blk_q || (flag_free && reached);

  always_comb begin
    blk_d = blk_q;
    cnt_d = cnt_q;
    if (win) begin
      blk_d = 1'b1;
      cnt_d = '0;
    end else if (flag_smp) begin
      if (!flag_free) begin
        cnt_d = '0;
      end else if (blk_q) begin
        if (reached) begin
          blk_d = 1'b0;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_inc[CNT_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= 1'b0;
      cnt_q <= '0;
    end else if (win || flag_smp) begin
      blk_q <= blk_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/wab_readback.sv
module wab_readback #(
  parameter int ADDR_W   = 3,
  parameter int POS_W    = 3,
  parameter int FLAG_POS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             octet_act,
  input  logic [POS_W-1:0] bit_pos,
  input  logic             bit_smp,
  input  logic             line_in,
  output logic             last_smp,
  output logic             idle_now
);
  localparam int               LSB_POS = FLAG_POS - ADDR_W;
  localparam logic [POS_W-1:0] FLAG_P  = POS_W'(FLAG_POS);
  localparam logic [POS_W-1:0] LSB_P   = POS_W'(LSB_POS);

  logic              free_q, free_d;
  logic [ADDR_W-1:0] sh_q, sh_d;
  logic              smp_v, in_field;
  logic [ADDR_W-1:0] field_now;

  assign smp_v     = octet_act && bit_smp;
  assign in_field  = (bit_pos >= LSB_P) && (bit_pos < FLAG_P);
  assign field_now = {sh_q[ADDR_W-2:0], line_in};
  assign last_smp  = smp_v && (bit_pos == LSB_P);
  assign idle_now  = free_q && (&field_now);

  always_comb begin
    free_d = free_q;
    sh_d   = sh_q;
    if (smp_v && bit_pos == FLAG_P) begin
      free_d = line_in;
      sh_d   = '0;
    end else if (smp_v && in_field) begin
      sh_d = field_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= 1'b0;
      sh_q   <= '0;
    end else if (smp_v) begin
      free_q <= free_d;
      sh_q   <= sh_d;
    end
  end
endmodule

// File: rtl/wab_arb_fsm.sv
module wab_arb_fsm
  import wab_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int POS_W    = 3,
  parameter int FLAG_POS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] my_addr,
  input  logic              req,
  input  logic              octet_act,
  input  logic [POS_W-1:0]  bit_pos,
  input  logic              bit_smp,
  input  logic              line_in,
  input  logic              bo_ok,
  output arb_st_e           st,
  output logic [POS_W-1:0]  exp_pos,
  output logic              send_bit,
  output logic              win
);
  localparam int               IDX_W   = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
  localparam int               LSB_POS = FLAG_POS - ADDR_W;
  localparam logic [POS_W-1:0] FLAG_P  = POS_W'(FLAG_POS);

  arb_st_e          st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             at_flag, at_mine;

  assign exp_pos  = POS_W'(LSB_POS) + POS_W'(idx_q);
  assign send_bit = my_addr[idx_q];
  assign at_flag  = octet_act && bit_smp && (bit_pos == FLAG_P);
  assign at_mine  = octet_act && bit_smp && (bit_pos == exp_pos);
  assign st       = st_q;

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    win   = 1'b0;
    unique case (st_q)
      ARB_IDLE: begin
        if (req && at_flag && line_in && bo_ok) begin
          st_d  = ARB_RUN;
          idx_d = IDX_W'(ADDR_W - 1);
        end
      end
      ARB_RUN: begin
        if (!req || at_flag) begin
          st_d = ARB_IDLE;
        end else if (at_mine) begin
          if (send_bit && !line_in) begin
            st_d = ARB_IDLE;
          end else if (idx_q == '0) begin
            st_d = ARB_HOLD;
            win  = 1'b1;
          end else begin
            idx_d = idx_q - IDX_W'(1);
          end
        end
      end
      ARB_HOLD: begin
        if (!req) st_d = ARB_IDLE;
      end
      default: st_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ARB_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end
endmodule

// File: rtl/wab_arbiter.sv
module wab_arbiter
  import wab_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int POS_W       = 3,
  parameter int FLAG_POS    = 5,
  parameter int FREE_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] my_addr,
  input  logic              sw_req,
  input  logic              tx_pend,
  input  logic              octet_act,
  input  logic [POS_W-1:0]  bit_pos,
  input  logic              bit_smp,
  input  logic              line_in,
  output logic              drv_en,
  output logic              grant
);
  localparam logic [POS_W-1:0] FLAG_P = POS_W'(FLAG_POS);

  logic             rst_sync_n;
  logic             req_w;
  arb_st_e          st_w;
  logic [POS_W-1:0] exp_pos_w;
  logic             send_bit_w, win_w, bo_ok_w;
  logic             flag_smp_w;
  logic             last_smp_w, idle_now_w;
  logic             dflt_q, dflt_d;

  assign req_w      = sw_req || tx_pend;
  assign flag_smp_w = octet_act && bit_smp && (bit_pos == FLAG_P);

  wab_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  wab_arb_fsm #(
    .ADDR_W   (ADDR_W),
    .POS_W    (POS_W),
    .FLAG_POS (FLAG_POS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .my_addr   (my_addr),
    .req       (req_w),
    .octet_act (octet_act),
    .bit_pos   (bit_pos),
    .bit_smp   (bit_smp),
    .line_in   (line_in),
    .bo_ok     (bo_ok_w),
    .st        (st_w),
    .exp_pos   (exp_pos_w),
    .send_bit  (send_bit_w),
    .win       (win_w)
  );

  wab_backoff #(
    .FREE_FRAMES (FREE_FRAMES)
  ) u_bo (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .win       (win_w),
    .flag_smp  (flag_smp_w),
    .flag_free (line_in),
    .ok        (bo_ok_w)
  );

  wab_readback #(
    .ADDR_W   (ADDR_W),
    .POS_W    (POS_W),
    .FLAG_POS (FLAG_POS)
  ) u_rb (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .octet_act (octet_act),
    .bit_pos   (bit_pos),
    .bit_smp   (bit_smp),
    .line_in   (line_in),
    .last_smp  (last_smp_w),
    .idle_now  (idle_now_w)
  );

  // default holder: all-ones address and an uncontended, free octet
  always_comb begin
    dflt_d = dflt_q;
    if (last_smp_w) dflt_d = (&my_addr) && idle_now_w;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)     dflt_q <= 1'b0;
    else if (last_smp_w) dflt_q <= dflt_d;
  end

  // open-drain drive: zeros only
  assign drv_en = octet_act &&
                  (((st_w == ARB_HOLD) && (bit_pos == FLAG_P)) ||
                   ((st_w == ARB_RUN) && (bit_pos == exp_pos_w) && !send_bit_w));

  assign grant = (st_w == ARB_HOLD) || dflt_q;
endmodule

// File: rtl/wab_arbiter_chk.sv
module wab_arbiter_chk
  import wab_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int POS_W    = 3,
  parameter int FLAG_POS = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_req,
  input logic             tx_pend,
  input logic             octet_act,
  input logic [POS_W-1:0] bit_pos,
  input logic             bit_smp,
  input logic             line_in,
  input logic             drv_en,
  input arb_st_e          st,
  input logic [POS_W-1:0] exp_pos,
  input logic             send_bit
);
  localparam logic [POS_W-1:0] FLAG_P = POS_W'(FLAG_POS);
  localparam logic [POS_W-1:0] LSB_P  = POS_W'(FLAG_POS - ADDR_W);

  p_drv_in_octet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> octet_act);

  p_drv_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_pos < LSB_P || bit_pos > FLAG_P) |-> !drv_en);

  p_start_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ARB_IDLE && !(octet_act && bit_smp && bit_pos == FLAG_P && line_in))
      |=> (st != ARB_RUN));

  p_lose_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ARB_RUN && octet_act && bit_smp && bit_pos == exp_pos && send_bit && !line_in)
      |=> (st == ARB_IDLE));

  p_hold_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ARB_HOLD && octet_act && bit_pos == FLAG_P) |-> drv_en);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_req && !tx_pend) |=> (st == ARB_IDLE));
endmodule

bind wab_arbiter wab_arbiter_chk #(
  .ADDR_W   (ADDR_W),
  .POS_W    (POS_W),
  .FLAG_POS (FLAG_POS)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .sw_req    (sw_req),
  .tx_pend   (tx_pend),
  .octet_act (octet_act),
  .bit_pos   (bit_pos),
  .bit_smp   (bit_smp),
  .line_in   (line_in),
  .drv_en    (drv_en),
  .st        (st_w),
  .exp_pos   (exp_pos_w),
  .send_bit  (send_bit_w)
);

// File: tb/wab_arbiter_tb_top.sv
module wab_arbiter_tb_top;
  logic       clk;
  logic       rst_n;
  logic       octet_act;
  logic [2:0] bit_pos;
  logic       bit_smp;
  logic       sw_a, tx_a, sw_b, tx_b, sw_c, tx_c;
  logic       drv_a, drv_b, drv_c;
  logic       gnt_a, gnt_b, gnt_c;
  wire        line = !(drv_a || drv_b || drv_c);

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  bit obs [8];

  initial clk = 1'b0;
  always #5 clk = ~clk;

  wab_arbiter dut_i (.clk(clk), .rst_n(rst_n), .my_addr(3'd2), .sw_req(sw_a), .tx_pend(tx_a),
    .octet_act(octet_act), .bit_pos(bit_pos), .bit_smp(bit_smp), .line_in(line),
    .drv_en(drv_a), .grant(gnt_a));
  wab_arbiter dut_b (.clk(clk), .rst_n(rst_n), .my_addr(3'd5), .sw_req(sw_b), .tx_pend(tx_b),
    .octet_act(octet_act), .bit_pos(bit_pos), .bit_smp(bit_smp), .line_in(line),
    .drv_en(drv_b), .grant(gnt_b));
  wab_arbiter dut_c (.clk(clk), .rst_n(rst_n), .my_addr(3'd7), .sw_req(sw_c), .tx_pend(tx_c),
    .octet_act(octet_act), .bit_pos(bit_pos), .bit_smp(bit_smp), .line_in(line),
    .drv_en(drv_c), .grant(gnt_c));

  // behavioural reference: 0 idle, 1 contending, 2 holding
  int m_addr [3] = '{2, 5, 7};
  int m_st [3], m_idx [3], m_blk [3], m_cnt [3], m_dflt [3];
  int m_fld, m_free;

  function automatic bit m_req(int k);
    case (k)
      0: return sw_a || tx_a;
      1: return sw_b || tx_b;
      default: return sw_c || tx_c;
    endcase
  endfunction

  function automatic bit m_drv(int k);
    if (!octet_act) return 0;
    if (m_st[k] == 2 && bit_pos == 3'd5) return 1;
    if (m_st[k] == 1 && int'(bit_pos) == 2 + m_idx[k] && ((m_addr[k] >> m_idx[k]) & 1) == 0) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) begin
        m_st[k] = 0; m_idx[k] = 0; m_blk[k] = 0; m_cnt[k] = 0; m_dflt[k] = 0;
      end
      m_fld = 0; m_free = 0;
    end else begin
      bit ln;
      ln = 1;
      for (int k = 0; k < 3; k++) if (m_drv(k)) ln = 0;
      if (octet_act && bit_smp && bit_pos == 3'd5) begin
        m_free = ln; m_fld = 0;
      end else if (octet_act && bit_smp && bit_pos >= 3'd2 && bit_pos <= 3'd4) begin
        m_fld = m_fld * 2 + ln;
      end
      for (int k = 0; k < 3; k++) begin
        bit may;
        may = 1;
        if (octet_act && bit_smp && bit_pos == 3'd5) begin
          if (!ln) m_cnt[k] = 0;
          else if (m_blk[k] != 0) begin
            m_cnt[k]++;
            if (m_cnt[k] >= 2) begin m_blk[k] = 0; m_cnt[k] = 0; end
          end
          may = (m_blk[k] == 0);
        end
        if (m_st[k] != 0 && !m_req(k)) m_st[k] = 0;
        else if (octet_act && bit_smp) begin
          if (bit_pos == 3'd5) begin
            if (m_st[k] == 1) m_st[k] = 0;
            else if (m_st[k] == 0 && m_req(k) && ln && may) begin m_st[k] = 1; m_idx[k] = 2; end
          end else if (m_st[k] == 1 && int'(bit_pos) == 2 + m_idx[k]) begin
            if (((m_addr[k] >> m_idx[k]) & 1) == 1 && !ln) m_st[k] = 0;
            else if (m_idx[k] == 0) begin m_st[k] = 2; m_blk[k] = 1; m_cnt[k] = 0; end
            else m_idx[k]--;
          end
        end
        if (octet_act && bit_smp && bit_pos == 3'd2)
          m_dflt[k] = (m_addr[k] == 7 && m_free == 1 && m_fld == 7) ? 1 : 0;
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every clock (R3 drive, R5 grant)
  always @(negedge clk) begin
    #3;
    if (rst_n && !done) begin
      chk(drv_a == m_drv(0), "R3 drive a", drv_a, m_drv(0));
      chk(drv_b == m_drv(1), "R3 drive b", drv_b, m_drv(1));
      chk(drv_c == m_drv(2), "R3 drive c", drv_c, m_drv(2));
      chk(gnt_a == (m_st[0] == 2 || m_dflt[0] != 0), "R5 grant a", gnt_a, int'(m_st[0] == 2 || m_dflt[0] != 0));
      chk(gnt_b == (m_st[1] == 2 || m_dflt[1] != 0), "R5 grant b", gnt_b, int'(m_st[1] == 2 || m_dflt[1] != 0));
      chk(gnt_c == (m_st[2] == 2 || m_dflt[2] != 0), "R8 grant c", gnt_c, int'(m_st[2] == 2 || m_dflt[2] != 0));
    end
  end

  task automatic run_frame();
    for (int p = 7; p >= 0; p--) begin
      @(negedge clk); octet_act = 1'b1; bit_pos = 3'(p); bit_smp = 1'b0;
      @(negedge clk); bit_smp = 1'b1;
      #2 obs[p] = line;
    end
    @(negedge clk); bit_smp = 1'b0; octet_act = 1'b0; bit_pos = 3'd0;
    repeat (3) @(negedge clk);
    #2;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; octet_act = 0; bit_pos = 0; bit_smp = 0;
    sw_a = 0; tx_a = 0; sw_b = 0; tx_b = 0; sw_c = 0; tx_c = 0;
    repeat (5) @(negedge clk);
    #2;
    chk(!drv_a && !drv_b && !drv_c, "R9 drive in reset", drv_a | drv_b | drv_c, 0);
    chk(!gnt_a && !gnt_b && !gnt_c, "R9 grant in reset", gnt_a | gnt_b | gnt_c, 0);
    @(negedge clk); rst_n = 1;
    repeat (5) @(negedge clk);
    #2;
    chk(!gnt_a && !gnt_b && !gnt_c, "R9 grant after reset", gnt_a | gnt_b | gnt_c, 0);

    // idle octet: address 7 holds by default
    run_frame();
    chk(gnt_c == 1, "R8 default holder", gnt_c, 1);
    chk(obs[4] && obs[3] && obs[2], "R8 idle field reads 7", {obs[4], obs[3], obs[2]}, 7);

    // a (2, software) and b (5, pending frame) contend
    @(negedge clk); sw_a = 1; tx_b = 1;
    run_frame();
    chk(gnt_a == 1, "R1 lowest address wins", gnt_a, 1);
    chk(gnt_b == 0, "R4 loser not granted", gnt_b, 0);
    chk(obs[3] == 1, "R4 loser released line", obs[3], 1);
    chk({obs[4], obs[3], obs[2]} == 3'b010, "R3 field msb first", {obs[4], obs[3], obs[2]}, 2);
    chk(obs[7] && obs[6] && obs[1] && obs[0], "R3 reserved bits idle", {obs[7], obs[6], obs[1], obs[0]}, 15);
    chk(gnt_c == 0, "R8 default cleared", gnt_c, 0);

    // held: flag driven low, b cannot start
    run_frame();
    chk(obs[5] == 0, "R5 flag held low", obs[5], 0);
    chk(gnt_b == 0, "R2 busy flag blocks start", gnt_b, 0);

    // a releases
    @(negedge clk); sw_a = 0;
    @(negedge clk); #2;
    chk(gnt_a == 0, "R6 grant falls", gnt_a, 0);
    run_frame();
    chk(obs[5] == 1, "R6 flag released", obs[5], 1);
    chk(gnt_b == 1, "R1 pending frame wins", gnt_b, 1);

    // a asks again while b holds; b then releases and asks again
    @(negedge clk); sw_a = 1;
    run_frame();
    @(negedge clk); tx_b = 0;
    @(negedge clk); tx_b = 1;
    run_frame();
    chk(gnt_a == 0, "R7 a waits first free octet", gnt_a, 0);
    chk(gnt_b == 0, "R7 b waits first free octet", gnt_b, 0);
    chk(gnt_c == 1, "R8 idle octet default", gnt_c, 1);
    run_frame();
    chk(gnt_a == 1, "R7 arbitrates on second free octet", gnt_a, 1);
    chk(gnt_b == 0, "R7 b loses on second free octet", gnt_b, 0);

    // only c contends: all-ones address sends nothing low and wins
    @(negedge clk); sw_a = 0; tx_b = 0; sw_c = 1;
    run_frame();
    chk(gnt_c == 1, "R5 address 7 wins", gnt_c, 1);
    chk(obs[4] && obs[3] && obs[2], "R3 ones released", {obs[4], obs[3], obs[2]}, 7);
    run_frame();
    chk(obs[5] == 0, "R5 c holds flag", obs[5], 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule